// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a source word left or right by an amount of up to one word width less one. The positions that the shift vacates are not zero-filled. Each one takes the bit at the same position of a separate fill word. The bits pushed out of the source are returned on a second output word, and a flag is raised when that word is nonzero. Chaining two such operations moves a multi-word value by a sub-word amount: the spill word of one step becomes the fill word of the next.

Both directions share one rotator. The source is rotated left by the shift amount, or by its two's complement for a right shift. A contiguous keep mask then chooses, bit by bit, between the rotated source and the fill word. The same rotated bits, masked by the complement of the keep mask, form the spill word. In the record form, the block also latches a 4-bit condition field, which gives a signed comparison of the primary result against zero together with the overflow indication. Outside the record form the field holds its value.

Top module: `dw_funnel_shift`

## Requirements
- R1: The shift amount n is the low log2(DATA_W) bits of `amt_i` (bits 5:0 at the default width). All higher bits of `amt_i` have no effect on any output.
- R2: Left shift (`dir_right_i`=0): `res_o` holds the source shifted left by n in bits W-1..n, and `fill_i` bits n-1..0 unchanged in bits n-1..0.
- R3: Left shift: `spill_o` holds the top n bits of the source in its bits n-1..0, and zero in all other bits.
- R4: Right shift (`dir_right_i`=1): `res_o` holds the source shifted right by n in bits W-1-n..0, and `fill_i` bits W-1..W-n unchanged in bits W-1..W-n.
- R5: Right shift: `spill_o` holds the bottom n bits of the source in its bits W-1..W-n, and zero in all other bits.
- R6: `ovf_o` is 1 exactly when `spill_o` is nonzero.
- R7: When n is 0, `res_o` equals the source, `spill_o` is zero and `ovf_o` is 0, in either direction.
- R8: `cond_o` is loaded only when `rec_i` is 1. After an operation with `rec_i`=0, `cond_o` keeps its previous value.
- R9: When loaded, `cond_o` bit 3 is 1 if `res_o` is negative as a signed value, bit 2 is 1 if it is positive and nonzero, bit 1 is 1 if it is zero, and bit 0 equals `ovf_o` of the same operation.
- R10: With OUT_REG=1 (the default), all outputs appear one clock after the inputs are presented. An active-low asynchronous reset clears `res_o`, `spill_o`, `ovf_o` and `cond_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | DATA_W | Word being shifted |
| fill_i | input | DATA_W | Supplies the vacated positions, bit for bit |
| amt_i | input | DATA_W | Shift-amount word; only its low bits are used |
| dir_right_i | input | 1 | 0 = shift left, 1 = shift right |
| rec_i | input | 1 | Record form: load the condition field |
| res_o | output | DATA_W | Primary result |
| spill_o | output | DATA_W | Bits shifted out of the source |
| ovf_o | output | 1 | Spill word is nonzero |
| cond_o | output | 4 | {negative, positive, zero, overflow} |

## Verification
On every cycle, the assertions hold the following: a zero shift passes the source through with an empty spill, the overflow flag agrees with the spill word, the condition field stays put without the record bit, and at most one of its three compare bits is set. Whether the right bits of the fill word survive, and whether the spilled bits land at the correct end, is shown only by the bench's scenarios. These cover both directions at amounts 0, 1, 4, 7, 8, 17, 32 and 63, with nonzero upper bits in the amount word, and compare the results with a shift-based model. The bench also checks the signed encoding of the condition field for negative, positive and zero results.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

   // Condition field: signed compare of the result against zero plus overflow
   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic ovf;
   } fsh_cond_t;

   function automatic fsh_cond_t fsh_make_cond(input logic sign_bit,
                                               input logic nonzero,
                                               input logic ovf);
      fsh_cond_t c;
      c.neg  = sign_bit;
      c.pos  = nonzero & ~sign_bit;
      c.zero = ~nonzero;
      c.ovf  = ovf;
      return c;
   endfunction

endpackage

// File: rtl/fsh_rotl.sv
module fsh_rotl #(
   parameter int W  = 64,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  data_i,
   input  logic [SW-1:0] amt_i,
   output logic [W-1:0]  data_o
);

   // Logarithmic barrel: stage s rotates by 2**s when amount bit s is set
   logic [W-1:0] stage [SW+1];

   assign stage[0] = data_i;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int D = 1 << s;
      assign stage[s+1] = amt_i[s] ? {stage[s][W-1-D:0], stage[s][W-1:W-D]}
                                   : stage[s];
   end

   assign data_o = stage[SW];

endmodule

// File: rtl/fsh_mask.sv
module fsh_mask #(
   parameter int W          = 64,
   parameter int SW         = $clog2(W),
   parameter bit BY_REVERSE = 1'b0
) (
   input  logic [SW-1:0] amt_i,
   input  logic          right_i,
   output logic [W-1:0]  keep_o
);

   localparam logic [W-1:0] ONES = '1;

   // Left keep mask: positions W-1..n come from the rotated source
   logic [W-1:0] lmask;
   assign lmask = ONES << amt_i;

   if (BY_REVERSE) begin : g_rev
      // Right mask is the left mask mirrored: no second shifter
      logic [W-1:0] rmask;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign rmask[i] = lmask[W-1-i];
      end
      assign keep_o = right_i ? rmask : lmask;
   end else begin : g_shift
      assign keep_o = right_i ? (ONES >> amt_i) : lmask;
   end

endmodule

// File: rtl/dw_funnel_shift.sv
module dw_funnel_shift
   import fsh_pkg::*;
#(
   parameter int DATA_W          = 64,
   parameter bit OUT_REG         = 1'b1,
   parameter bit MASK_BY_REVERSE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] fill_i,
   input  logic [DATA_W-1:0] amt_i,
   input  logic              dir_right_i,
   input  logic              rec_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] spill_o,
   output logic              ovf_o,
   output logic [3:0]        cond_o
);

   localparam int SHW = $clog2(DATA_W);

   if (DATA_W < 8 || (1 << SHW) != DATA_W) begin : g_bad_width
      $error("dw_funnel_shift: DATA_W must be a power of two of at least 8");
   end

   // Shift amount: low bits only (R1)
   logic [SHW-1:0] amt_n;
   logic [SHW-1:0] rot_amt;
   assign amt_n   = amt_i[SHW-1:0];
   assign rot_amt = dir_right_i ? (SHW'(0) - amt_n) : amt_n;

   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] keep;

   fsh_rotl #(.W(DATA_W), .SW(SHW)) u_rotl (
      .data_i (src_i),
      .amt_i  (rot_amt),
      .data_o (rotated)
   );

   fsh_mask #(.W(DATA_W), .SW(SHW), .BY_REVERSE(MASK_BY_REVERSE)) u_mask (
      .amt_i   (amt_n),
      .right_i (dir_right_i),
      .keep_o  (keep)
   );

   // Mask merge: kept rotated bits, fill word in vacated positions
   logic [DATA_W-1:0] res_n;
   logic [DATA_W-1:0] spill_n;
   logic              ovf_n;
   fsh_cond_t         cond_n;
   assign res_n   = (rotated & keep) | (fill_i & ~keep);
   assign spill_n = rotated & ~keep;
   assign ovf_n   = |spill_n;
   assign cond_n  = fsh_make_cond(res_n[DATA_W-1], |res_n, ovf_n);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o   <= '0;
            spill_o <= '0;
            ovf_o   <= 1'b0;
         end else begin
            res_o   <= res_n;
            spill_o <= spill_n;
            ovf_o   <= ovf_n;
         end
      end

      // R7: zero amount passes the source straight through
      assert_zero_amt_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (amt_i[SHW-1:0] == '0) |=> (res_o == $past(src_i) && spill_o == '0 && !ovf_o));
   end else begin : g_comb
      assign res_o   = res_n;
      assign spill_o = spill_n;
      assign ovf_o   = ovf_n;
   end

   // Condition field is loaded only in the record form (R8, R9)
   fsh_cond_t cond_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cond_q <= '0;
      else if (rec_i) cond_q <= cond_n;
   end
   assign cond_o = cond_q;

   // R6: overflow flag agrees with the spill word
   assert_ovf_spill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o == (spill_o != '0));

   // R8: non-record operation leaves the field untouched
   assert_cond_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_i |=> $stable(cond_o));

   // R9: compare bits are mutually exclusive
   assert_cond_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cond_o[3:1]) <= 1);

endmodule

// File: tb/sim_dw_funnel_shift.sv
`timescale 1ns/1ps
module sim_dw_funnel_shift;

   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] src_i = '0, fill_i = '0, amt_i = '0;
   logic         dir_right_i = 1'b0, rec_i = 1'b0;
   logic [W-1:0] res_o, spill_o;
   logic         ovf_o;
   logic [3:0]   cond_o;

   always #2 clk = ~clk;   // 250 MHz

   dw_funnel_shift u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .fill_i(fill_i), .amt_i(amt_i),
      .dir_right_i(dir_right_i), .rec_i(rec_i), .res_o(res_o), .spill_o(spill_o),
      .ovf_o(ovf_o), .cond_o(cond_o)
   );

   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] c;
      logic [W-1:0] b;
      logic         right;
      logic         rec;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4,  1'b0, 1'b1},
      '{64'h0123_4567_89AB_CDEF, 64'h0,                   64'd8,  1'b1, 1'b1},
      '{64'h8000_0000_0000_0001, 64'h5555_5555_5555_5555, 64'd1,  1'b0, 1'b1},
      '{64'h8000_0000_0000_0001, 64'h5555_5555_5555_5555, 64'd1,  1'b1, 1'b1},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   64'd63, 1'b0, 1'b1},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   64'd63, 1'b1, 1'b1},
      '{64'h00FF_00FF_00FF_00FF, 64'hAAAA_AAAA_AAAA_AAAA, 64'd32, 1'b0, 1'b0},
      '{64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 64'd17, 1'b1, 1'b1},
      '{64'h0000_0000_0000_0001, 64'h1234_0000_0000_4321, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0, 1'b1},
      '{64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0107, 1'b1, 1'b0}
   };

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic [3:0] cond_exp = 4'b0;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Independent model built from plain shifts (R1-style low-bit amount)
   function automatic void model(input vec_t v, output logic [W-1:0] r, output logic [W-1:0] s);
      int n;
      logic [W-1:0] low;
      n   = int'(v.b[5:0]);
      low = (n == 0) ? '0 : ({W{1'b1}} >> (W - n));
      if (!v.right) begin
         r = (v.a << n) | (v.c & low);
         s = (n == 0) ? '0 : (v.a >> (W - n));
      end else begin
         r = (v.a >> n) | (v.c & ~({W{1'b1}} >> n));
         s = (n == 0) ? '0 : (v.a << (W - n));
      end
   endfunction

   task automatic run_vec(input vec_t v, input string tag);
      logic [W-1:0] er, es;
      logic         eo;
      model(v, er, es);
      eo = (es != '0);
      if (v.rec)
         cond_exp = {er[W-1], (er != '0) & ~er[W-1], (er == '0), eo};
      @(negedge clk);
      src_i = v.a; fill_i = v.c; amt_i = v.b; dir_right_i = v.right; rec_i = v.rec;
      @(negedge clk);   // one register stage (R10)
      check({tag, v.right ? " R4 result" : " R2 result"}, res_o, er);
      check({tag, v.right ? " R5 spill" : " R3 spill"}, spill_o, es);
      check({tag, " R6 overflow"}, W'(ovf_o), W'(eo));
      check({tag, v.rec ? " R9 cond" : " R8 cond hold"}, W'(cond_o), W'(cond_exp));
   endtask

   initial begin
      #3;
      // R10: reset state
      check("R10 reset res", res_o, '0);
      check("R10 reset spill", spill_o, '0);
      check("R10 reset ovf", W'(ovf_o), '0);
      check("R10 reset cond", W'(cond_o), '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

      // R1 / R7: zero amount with junk in the upper amount bits, right direction
      run_vec('{64'hFEDC_BA98_7654_3210, 64'hFFFF_0000_FFFF_0000, 64'hABCD_0000_0000_0040, 1'b1, 1'b1}, "R1 R7 zero");
      check("R7 passthrough", res_o, 64'hFEDC_BA98_7654_3210);
      // R1: same low amount, different upper bits give identical results
      run_vec('{64'h0F0F_0000_0000_F0F0, 64'h0, 64'h0000_0000_0000_0004, 1'b0, 1'b1}, "R1 base");
      check("R1 upper ignored base", res_o, 64'hF0F0_0000_000F_0F00);
      run_vec('{64'h0F0F_0000_0000_F0F0, 64'h0, 64'h8000_1234_0000_0F04, 1'b0, 1'b1}, "R1 junk");
      check("R1 upper ignored junk", res_o, 64'hF0F0_0000_000F_0F00);
      // R9: positive nonzero result, then R8: non-record op on negative result keeps it
      run_vec('{64'h0000_0000_0000_0010, 64'h0, 64'd1, 1'b1, 1'b1}, "R9 pos");
      check("R9 positive code", W'(cond_o), W'(4'b0100));
      run_vec('{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, 1'b0}, "R8 norec");
      check("R8 cond unchanged", W'(cond_o), W'(4'b0100));
      // R9: zero result with overflow
      run_vec('{64'h8000_0000_0000_0000, 64'h0, 64'd1, 1'b0, 1'b1}, "R9 zero");
      check("R9 zero+ovf code", W'(cond_o), W'(4'b0011));

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule